// File: doc/BRIEF.md
# Accumulator ALU with Flags

This block is the arithmetic and logic stage for a small 8-bit accumulator machine. It takes the accumulator value and one operand byte, which may come from a register, from memory or from an immediate. It applies one of eight two-operand functions, or one of four rotate forms of the accumulator. It returns the new accumulator value with a write strobe and keeps a four-bit flag set: carry, even parity, zero and sign.

A second, independent path increments or decrements a byte from the general register file. The accumulator is never the target of this path. It updates parity, zero and sign and leaves carry as it was.

Every result is registered and appears one clock after the request. The carry used by add-with-carry, subtract-with-borrow and the through-carry rotates is the block's own registered carry flag. Operand fetch and register storage belong to the surrounding datapath.

Top module: `acc_alu_flags`

## Requirements
- R1: While `rst` is high at a clock edge, `acc_out`, `step_out`, `acc_we`, `step_we` and all four flags are 0.
- R2: With `alu_go` and `alu_op` 000, the result is `acc_in + opnd_in`. With 001 the registered carry is also added. Carry becomes the bit shifted out of the top.
- R3: With `alu_op` 010, the result is `acc_in - opnd_in`. With 011 the registered carry is also subtracted. Carry becomes 1 exactly when a borrow occurs.
- R4: `alu_op` 100, 101 and 110 give bitwise AND, XOR and OR. Each clears carry.
- R5: `alu_op` 111 (compare) sets the flags as subtract does. It leaves `acc_we` low and `acc_out` unchanged.
- R6: After any two-operand operation, parity is 1 when the result has an even number of ones. Zero is 1 when the result is 0. Sign is the result's top bit.
- R7: With `rot_go`, `rot_sel` 00 rotates left so that the old top bit enters both bit 0 and carry. `rot_sel` 01 rotates right so that the old bit 0 enters both the top bit and carry.
- R8: `rot_sel` 10 rotates left through carry: the old carry enters bit 0 and the old top bit becomes carry. `rot_sel` 11 rotates right through carry: the old carry enters the top bit and the old bit 0 becomes carry.
- R9: A rotate changes only carry among the flags.
- R10: With `step_go`, `step_out` becomes `step_in + 1` when `step_down` is 0 and `step_in - 1` when it is 1, wrapping modulo 2^W. Parity, zero and sign follow the new value and carry is kept.
- R11: Results and flags appear at the first clock edge after the request. `acc_we` and `step_we` are high for exactly one cycle for each request that writes.
- R12: When requests coincide, `alu_go` wins over `rot_go`, which wins over `step_go`. Only the winner has any effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alu_go | input | 1 | Request a two-operand operation |
| alu_op | input | 3 | Operation select (see R2 to R5) |
| rot_go | input | 1 | Request an accumulator rotate |
| rot_sel | input | 2 | Rotate form (see R7, R8) |
| step_go | input | 1 | Request a register increment or decrement |
| step_down | input | 1 | 0 increments, 1 decrements |
| acc_in | input | W | Current accumulator value |
| opnd_in | input | W | Second operand |
| step_in | input | W | Register value to step |
| acc_out | output | W | Registered new accumulator value |
| acc_we | output | 1 | Accumulator write strobe |
| step_out | output | W | Registered stepped register value |
| step_we | output | 1 | Register write strobe |
| flag_c | output | 1 | Carry / borrow flag |
| flag_p | output | 1 | Even-parity flag |
| flag_z | output | 1 | Zero flag |
| flag_s | output | 1 | Sign flag |

## Verification
The bench builds the block at its default width W=8. At that width every pair of accumulator and operand values, 65,536 in all, can be driven in one sweep. The operation code rotates through the sweep, so each operation sees a broad spread of operand pairs. The carry chains from one step to the next, so add-with-carry and subtract-with-borrow meet both incoming carry values. At this width the wrap cases for increment and decrement and the all-ones and zero boundaries are also reachable directly.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_ADC = 3'd1,
    OP_SUB = 3'd2,
    OP_SBB = 3'd3,
    OP_AND = 3'd4,
    OP_XOR = 3'd5,
    OP_OR  = 3'd6,
    OP_CMP = 3'd7
  } alu_op_e;

  typedef enum logic [1:0] {
    ROT_LEFT_CIRC  = 2'd0,
    ROT_RIGHT_CIRC = 2'd1,
    ROT_LEFT_THRU  = 2'd2,
    ROT_RIGHT_THRU = 2'd3
  } rot_sel_e;

  typedef struct packed {
    logic c;
    logic p;
    logic z;
    logic s;
  } flags_t;
endpackage

// File: rtl/alu_arith.sv
module alu_arith
  import alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_e      op,
  input  logic         cin,
  output logic [W-1:0] res,
  output logic         cout,
  output logic         wr
);
  localparam int XW = W + 1;
  logic [XW-1:0] wide;
  logic [XW-1:0] cext;

  always_comb begin
    cext = '0;
    wide = '0;
    cout = 1'b0;
    res  = '0;
    wr   = (op != OP_CMP);
    unique case (op)
      OP_ADD, OP_ADC: begin
        cext[0] = (op == OP_ADC) ? cin : 1'b0;
        wide = {1'b0, a} + {1'b0, b} + cext;
        res  = wide[W-1:0];
        cout = wide[W];
      end
      OP_SUB, OP_SBB, OP_CMP: begin
        cext[0] = (op == OP_SBB) ? cin : 1'b0;
        wide = {1'b0, a} - {1'b0, b} - cext;
        res  = wide[W-1:0];
        cout = wide[W];
      end
      OP_AND: res = a & b;
      OP_XOR: res = a ^ b;
      OP_OR:  res = a | b;
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/alu_rotate.sv
module alu_rotate
  import alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  rot_sel_e     sel,
  input  logic         cin,
  output logic [W-1:0] res,
  output logic         cout
);
  always_comb begin
    unique case (sel)
      ROT_LEFT_CIRC:  begin res = {a[W-2:0], a[W-1]}; cout = a[W-1]; end
      ROT_RIGHT_CIRC: begin res = {a[0], a[W-1:1]};   cout = a[0];   end
      ROT_LEFT_THRU:  begin res = {a[W-2:0], cin};    cout = a[W-1]; end
      default:        begin res = {cin, a[W-1:1]};    cout = a[0];   end
    endcase
  end
endmodule

// File: rtl/alu_step.sv
module alu_step #(
  parameter int W = 8
) (
  input  logic [W-1:0] v,
  input  logic         down,
  output logic [W-1:0] res
);
  localparam logic [W-1:0] ONE = W'(1);
  always_comb res = down ? (v - ONE) : (v + ONE);
endmodule

// File: rtl/alu_pzs.sv
module alu_pzs #(
  parameter int W = 8
) (
  input  logic [W-1:0] v,
  output logic         p,
  output logic         z,
  output logic         s
);
  always_comb begin
    p = ~(^v);
    z = (v == '0);
    s = v[W-1];
  end
endmodule

// File: rtl/acc_alu_flags.sv
module acc_alu_flags
  import alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         alu_go,
  input  logic [2:0]   alu_op,
  input  logic         rot_go,
  input  logic [1:0]   rot_sel,
  input  logic         step_go,
  input  logic         step_down,
  input  logic [W-1:0] acc_in,
  input  logic [W-1:0] opnd_in,
  input  logic [W-1:0] step_in,
  output logic [W-1:0] acc_out,
  output logic         acc_we,
  output logic [W-1:0] step_out,
  output logic         step_we,
  output logic         flag_c,
  output logic         flag_p,
  output logic         flag_z,
  output logic         flag_s
);
  localparam int NPZS = 2;

  flags_t        fl_q;
  logic [W-1:0]  ar_res, ro_res, st_res;
  logic          ar_c, ar_wr, ro_c;
  logic [W-1:0]  pzs_in  [NPZS];
  logic          pzs_p   [NPZS];
  logic          pzs_z   [NPZS];
  logic          pzs_s   [NPZS];

  alu_arith #(.W(W)) u_arith (
    .a(acc_in), .b(opnd_in), .op(alu_op_e'(alu_op)), .cin(fl_q.c),
    .res(ar_res), .cout(ar_c), .wr(ar_wr)
  );

  alu_rotate #(.W(W)) u_rot (
    .a(acc_in), .sel(rot_sel_e'(rot_sel)), .cin(fl_q.c),
    .res(ro_res), .cout(ro_c)
  );

  alu_step #(.W(W)) u_step (.v(step_in), .down(step_down), .res(st_res));

  assign pzs_in[0] = ar_res;
  assign pzs_in[1] = st_res;

  for (genvar g = 0; g < NPZS; g++) begin : g_pzs
    alu_pzs #(.W(W)) u_pzs (
      .v(pzs_in[g]), .p(pzs_p[g]), .z(pzs_z[g]), .s(pzs_s[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fl_q     <= '0;
      acc_out  <= '0;
      step_out <= '0;
      acc_we   <= 1'b0;
      step_we  <= 1'b0;
    end else begin
      acc_we  <= 1'b0;
      step_we <= 1'b0;
      if (alu_go) begin
        fl_q <= '{c: ar_c, p: pzs_p[0], z: pzs_z[0], s: pzs_s[0]};
        if (ar_wr) begin
          acc_out <= ar_res;
          acc_we  <= 1'b1;
        end
      end else if (rot_go) begin
        fl_q.c  <= ro_c;
        acc_out <= ro_res;
        acc_we  <= 1'b1;
      end else if (step_go) begin
        fl_q.p   <= pzs_p[1];
        fl_q.z   <= pzs_z[1];
        fl_q.s   <= pzs_s[1];
        step_out <= st_res;
        step_we  <= 1'b1;
      end
    end
  end

  assign flag_c = fl_q.c;
  assign flag_p = fl_q.p;
  assign flag_z = fl_q.z;
  assign flag_s = fl_q.s;

  // R5: compare never writes the accumulator and holds its value
  a_r5_cmp_no_write: assert property (@(posedge clk) disable iff (rst)
    (alu_go && alu_op == 3'b111) |=> (!acc_we && $stable(acc_out)));

  // R4: logical operations leave carry clear
  a_r4_logic_clears_c: assert property (@(posedge clk) disable iff (rst)
    (alu_go && alu_op inside {3'b100, 3'b101, 3'b110}) |=> !flag_c);

  // R9: rotates touch only carry
  a_r9_rot_keeps_pzs: assert property (@(posedge clk) disable iff (rst)
    (rot_go && !alu_go) |=> ($stable(flag_p) && $stable(flag_z) && $stable(flag_s)));

  // R10: increment/decrement keeps carry, zero tracks the stepped value
  a_r10_step_keeps_c: assert property (@(posedge clk) disable iff (rst)
    (step_go && !alu_go && !rot_go) |=> $stable(flag_c));
  a_r10_step_zero: assert property (@(posedge clk) disable iff (rst)
    step_we |-> (flag_z == (step_out == '0)));

  // R12: at most one write strobe per cycle
  a_r12_one_winner: assert property (@(posedge clk) disable iff (rst)
    $onehot0({acc_we, step_we}));

  // R11: a strobe lasts one cycle unless a new request arrived
  a_r11_pulse: assert property (@(posedge clk) disable iff (rst)
    (!alu_go && !rot_go) |=> !acc_we);
endmodule

// File: tb/sim_acc_alu_flags.sv
module sim_acc_alu_flags;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst;
  logic         alu_go, rot_go, step_go, step_down;
  logic [2:0]   alu_op;
  logic [1:0]   rot_sel;
  logic [W-1:0] acc_in, opnd_in, step_in;
  logic [W-1:0] acc_out, step_out;
  logic         acc_we, step_we, flag_c, flag_p, flag_z, flag_s;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // model state
  logic [W-1:0] m_acc, m_step;
  logic         m_c, m_p, m_z, m_s;

  always #10 clk = ~clk;

  acc_alu_flags #(.W(W)) u0 (
    .clk(clk), .rst(rst), .alu_go(alu_go), .alu_op(alu_op), .rot_go(rot_go),
    .rot_sel(rot_sel), .step_go(step_go), .step_down(step_down),
    .acc_in(acc_in), .opnd_in(opnd_in), .step_in(step_in),
    .acc_out(acc_out), .acc_we(acc_we), .step_out(step_out), .step_we(step_we),
    .flag_c(flag_c), .flag_p(flag_p), .flag_z(flag_z), .flag_s(flag_s)
  );

  task automatic chk(input string tag, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
    end
  endtask

  task automatic chk_state(input string tag, input logic exp_awe, input logic exp_swe);
    chk(tag, "acc_out", acc_out, m_acc);
    chk(tag, "acc_we", acc_we, exp_awe);
    chk(tag, "step_out", step_out, m_step);
    chk(tag, "step_we", step_we, exp_swe);
    chk(tag, "flags cpzs", {flag_c, flag_p, flag_z, flag_s}, {m_c, m_p, m_z, m_s});
  endtask

  task automatic set_pzs(input logic [W-1:0] v);
    m_p = ~(^v);
    m_z = (v == 0);
    m_s = v[W-1];
  endtask

  task automatic idle();
    alu_go = 0; rot_go = 0; step_go = 0;
  endtask

  // Expected result of a two-operand operation, per R2-R6
  task automatic alu_model(input logic [2:0] op, input logic [W-1:0] a, input logic [W-1:0] b);
    int t;
    logic [W-1:0] r;
    logic c;
    case (op)
      3'd0: begin t = int'(a) + int'(b); r = W'(t); c = t > 255; end
      3'd1: begin t = int'(a) + int'(b) + int'(m_c); r = W'(t); c = t > 255; end
      3'd2, 3'd7: begin t = int'(a) - int'(b); r = W'(t); c = t < 0; end
      3'd3: begin t = int'(a) - int'(b) - int'(m_c); r = W'(t); c = t < 0; end
      3'd4: begin r = a & b; c = 0; end
      3'd5: begin r = a ^ b; c = 0; end
      default: begin r = a | b; c = 0; end
    endcase
    m_c = c;
    set_pzs(r);
    if (op != 3'd7) m_acc = r;
  endtask

  // Caller stands at a negedge; result checked at the next negedge.
  task automatic do_alu(input logic [2:0] op, input logic [W-1:0] a, input logic [W-1:0] b);
    string tag;
    tag = (op < 2) ? "R2" : (op < 4) ? "R3" : (op < 7) ? "R4" : "R5";
    alu_go = 1; rot_go = 0; step_go = 0;
    alu_op = op; acc_in = a; opnd_in = b;
    alu_model(op, a, b);
    @(negedge clk);
    chk(tag, "acc_out", acc_out, m_acc);
    chk(tag, "acc_we", acc_we, op != 3'd7);
    chk("R6", "flags cpzs", {flag_c, flag_p, flag_z, flag_s}, {m_c, m_p, m_z, m_s});
  endtask

  task automatic do_rot(input string tag, input logic [1:0] sel, input logic [W-1:0] a);
    logic nc;
    alu_go = 0; rot_go = 1; step_go = 0;
    rot_sel = sel; acc_in = a;
    case (sel)
      2'd0: begin m_acc = {a[W-2:0], a[W-1]}; nc = a[W-1]; end
      2'd1: begin m_acc = {a[0], a[W-1:1]};   nc = a[0];   end
      2'd2: begin m_acc = {a[W-2:0], m_c};    nc = a[W-1]; end
      default: begin m_acc = {m_c, a[W-1:1]}; nc = a[0];   end
    endcase
    m_c = nc;
    @(negedge clk);
    chk_state(tag, 1'b1, 1'b0);
  endtask

  task automatic do_step(input logic down, input logic [W-1:0] v);
    alu_go = 0; rot_go = 0; step_go = 1;
    step_down = down; step_in = v;
    m_step = down ? v - 1'b1 : v + 1'b1;
    set_pzs(m_step);
    @(negedge clk);
    chk_state("R10", 1'b0, 1'b1);
  endtask

  task automatic t_reset();
    rst = 1; idle();
    alu_op = 0; rot_sel = 0; step_down = 0;
    acc_in = 8'hA5; opnd_in = 8'h5A; step_in = 8'h33;
    alu_go = 1; step_go = 1;
    repeat (3) @(negedge clk);
    m_acc = 0; m_step = 0; m_c = 0; m_p = 0; m_z = 0; m_s = 0;
    chk_state("R1", 1'b0, 1'b0);
    rst = 0; idle();
    @(negedge clk);
    chk_state("R1", 1'b0, 1'b0);
  endtask

  task automatic t_corners();
    do_alu(3'd0, 8'hFF, 8'h01);  // R2 wrap to zero, carry out
    do_alu(3'd1, 8'h10, 8'h20);  // R2 carry 1 added -> 31
    chk("R2", "adc value", acc_out, 8'h31);
    do_alu(3'd2, 8'h00, 8'h01);  // R3 borrow -> FF
    chk("R3", "borrow", flag_c, 1);
    do_alu(3'd3, 8'h05, 8'h02);  // R3 subtract borrow -> 02
    chk("R3", "sbb value", acc_out, 8'h02);
    do_alu(3'd2, 8'h80, 8'h80);  // zero result, no borrow
    do_alu(3'd7, 8'h42, 8'h42);  // R5 equal compare
    chk("R5", "cmp zero", flag_z, 1);
    do_alu(3'd7, 8'h01, 8'h02);  // R5 compare borrow
    chk("R5", "cmp borrow", flag_c, 1);
    do_alu(3'd4, 8'hF0, 8'h3C);  // R4 clears carry
    chk("R4", "and clears c", flag_c, 0);
    do_alu(3'd5, 8'hFF, 8'h0F);
    do_alu(3'd6, 8'h00, 8'h00);
    idle();
    @(negedge clk);
    chk("R11", "acc_we drop", acc_we, 0);
  endtask

  task automatic t_sweep();
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b++)
        do_alu(3'((a + b) % 8), W'(a), W'(b));
    idle();
    @(negedge clk);
  endtask

  task automatic t_rotates();
    do_alu(3'd4, 8'h00, 8'h00);          // carry 0, Z=1, P=1
    do_rot("R7", 2'd0, 8'h81);           // 03, c=1
    do_rot("R7", 2'd1, 8'h01);           // 80, c=1
    do_rot("R8", 2'd2, 8'h40);           // 81 (carry in), c=0
    do_rot("R8", 2'd3, 8'h01);           // 00, c=1
    do_rot("R8", 2'd3, 8'h00);           // 80, c=0
    do_rot("R9", 2'd2, 8'h80);           // 00, c=1, pzs unchanged
    idle();
    @(negedge clk);
    chk("R11", "rot we drop", acc_we, 0);
  endtask

  task automatic t_step();
    do_alu(3'd0, 8'hF0, 8'h20);          // sets carry 1
    do_step(1'b0, 8'hFF);                // wraps to 00, carry kept
    do_step(1'b1, 8'h00);                // wraps to FF
    do_step(1'b0, 8'h7F);
    do_step(1'b1, 8'h01);
    chk("R10", "carry kept", flag_c, 1);
    idle();
    @(negedge clk);
    chk("R11", "step_we drop", step_we, 0);
  endtask

  task automatic t_priority();
    logic [W-1:0] old_step;
    old_step = m_step;
    step_in = 8'h10; step_down = 0; rot_sel = 2'd0;
    rot_go = 1; step_go = 1;
    alu_go = 1; alu_op = 3'd6; acc_in = 8'h0C; opnd_in = 8'h30;
    alu_model(3'd6, 8'h0C, 8'h30);
    @(negedge clk);
    chk_state("R12", 1'b1, 1'b0);
    chk("R12", "step held", step_out, old_step);
    alu_go = 0; acc_in = 8'h81;
    m_acc = 8'h03; m_c = 1;
    @(negedge clk);
    chk_state("R12", 1'b1, 1'b0);
    idle();
    @(negedge clk);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_corners();
    t_rotates();
    t_step();
    t_priority();
    t_sweep();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule